// File: doc/BRIEF.md
# MSI Address Composer and Sender

This block turns interrupt requests of a domain that runs in message-signalled mode into 32-bit memory writes. Each source has a target word naming a destination hart, a guest file and an interrupt identity. When the domain is enabled and a source is both enabled and pending, the block reads that source's target word and builds a 64-bit physical address from a base page number and the hart index. The hart index is split into a group part and a low part, and each part is placed at a programmable width and shift. The block then presents one write request with the identity as data, and pulses a clear for that source's pending bit.

Two register windows hold the address layout: one for a machine-level domain and one for a supervisor-level domain. The `dom_is_mach` strap selects the window. A machine-level domain always sends guest index 0. A lock bit in the machine high register freezes both windows until reset. Software can also send a message directly by writing a send register. Only one message is ever outstanding. Among waiting requests the software send is served first, and after it the lowest-numbered source.

Top module: `msi_composer`

## Requirements
- R1: After a synchronous reset, `msi_valid` is 0, `pend_clr` is 0, and every register reads 0, so the domain is disabled.
- R2: Register index map: 0 control (bit 0 = domain enable), 1 machine base low, 2 machine high, 3 supervisor base low, 4 supervisor high, 5 software send. Indices 6 and 7 read 0. Reads are combinational on `reg_addr`. Both high registers keep only the bits under mask 0x9F77FFFF. Their fields are: lock at 31, group shift at 28:24, low shift at 22:20, group width at 18:16, low width at 15:12, and upper base page at 11:0.
- R3: Once bit 31 of the machine high register is 1, writes to indices 1 to 4 are ignored until reset.
- R4: A source message starts only when the domain enable is 1, the source's enable and pending inputs are both 1, and no message is in flight.
- R5: The address is the page number shifted left by 12. The page number is the OR of these terms: the base ({high[11:0], low}); (hart >> lowwidth) masked to groupwidth bits and shifted left by groupshift+12; (hart masked to lowwidth bits) shifted left by lowshift; and the guest masked to lowshift bits.
- R6: With `dom_is_mach`=1, the machine window is used and the guest index is 0. With `dom_is_mach`=0, the supervisor window and the target's guest field are used.
- R7: `pend_clr` is a one-hot, single-cycle pulse on the served source. It occurs in the cycle at whose closing edge `msi_valid` rises.
- R8: A waiting software send is served before any source. Among ready sources, the lowest index is served first.
- R9: At most one message is outstanding. `msi_valid`, `msi_addr` and `msi_data` hold while `msi_ready` is 0. After the handshake edge, `msi_valid` is 0 for at least one cycle.
- R10: A write to index 5 stores the value with bits 17:12 cleared. It requests a message with hart bits 31:18, identity bits 10:0 and guest 0, whatever the domain enable.
- R11: Target words carry the hart in 31:18, the guest in 17:12 and the identity in 10:0. `msi_data` is the identity zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dom_is_mach | input | 1 | 1 = machine-level domain, 0 = supervisor-level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| src_target | input | NSRC*32 | Target words, source i at bits i*32 +: 32 |
| src_pend | input | NSRC | Pending bit per source |
| src_en | input | NSRC | Enable bit per source |
| pend_clr | output | NSRC | One-cycle clear of the served source's pending bit |
| msi_valid | output | 1 | Write request valid |
| msi_ready | input | 1 | Write request accepted |
| msi_addr | output | 64 | Write address |
| msi_data | output | 32 | Write data (identity) |

## Verification
The assertions assume that the environment drops a source's pending input no later than the edge after `pend_clr` names it. They also assume that it neither withdraws nor changes a request the block has already launched. The bench pending vector models this. It clears the bit as the served source's pulse ends and sets bits only at falling edges. The bench keeps the lock bit clear during its random register traffic, so that lock behaviour is tested in its own phase. It changes `dom_is_mach` only at falling edges, and the model samples that value in the same cycle as the design.

// File: rtl/msi_pkg.sv
package msi_pkg;

    localparam int WORD_W   = 32;
    localparam int MADDR_W  = 64;
    localparam int HART_W   = 14;
    localparam int GUEST_W  = 6;
    localparam int EIID_W   = 11;
    localparam int LOCK_BIT = 31;
    localparam int PAGE_SH  = 12;

    localparam logic [WORD_W-1:0] HI_KEEP = 32'h9F77_FFFF;
    localparam logic [WORD_W-1:0] SW_KEEP = 32'hFFFC_0FFF;

    typedef enum logic [2:0] {
        RI_CTRL   = 3'd0,
        RI_MLO    = 3'd1,
        RI_MHI    = 3'd2,
        RI_SLO    = 3'd3,
        RI_SHI    = 3'd4,
        RI_SWSEND = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic [HART_W-1:0]  hart;
        logic [GUEST_W-1:0] guest;
        logic [EIID_W-1:0]  eiid;
    } dest_t;

    typedef struct packed {
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
    } win_t;

    typedef struct packed {
        logic [MADDR_W-1:0] addr;
        logic [WORD_W-1:0]  data;
    } msg_t;

    function automatic dest_t unpack_target(logic [WORD_W-1:0] w);
        dest_t d;
        d.hart  = w[31:18];
        d.guest = w[17:12];
        d.eiid  = w[10:0];
        return d;
    endfunction

    function automatic msg_t build_msg(win_t w, dest_t d);
        msg_t m;
        logic [3:0] lw;
        logic [2:0] hw;
        logic [2:0] ls;
        logic [4:0] hs;
        logic [6:0] hsh;
        logic [63:0] hart64, grp, low, gst, ppn;
        lw     = w.hi[15:12];
        hw     = w.hi[18:16];
        ls     = w.hi[22:20];
        hs     = w.hi[28:24];
        hsh    = {2'b00, hs} + 7'd12;
        hart64 = {{(64-HART_W){1'b0}}, d.hart};
        grp    = (hart64 >> lw) & ((64'd1 << hw) - 64'd1);
        low    = (hart64 & ((64'd1 << lw) - 64'd1)) << ls;
        gst    = {{(64-GUEST_W){1'b0}}, d.guest} & ((64'd1 << ls) - 64'd1);
        ppn    = {20'd0, w.hi[11:0], w.lo} | (grp << hsh) | low | gst;
        m.addr = ppn << PAGE_SH;
        m.data = {{(WORD_W-EIID_W){1'b0}}, d.eiid};
        return m;
    endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
    import msi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              sw_take,
    output logic [WORD_W-1:0] rdata,
    output logic              dom_en,
    output win_t              win_m,
    output win_t              win_s,
    output logic [WORD_W-1:0] sw_word,
    output logic              sw_req
);

    reg_idx_e sel;
    logic     locked;

    assign sel    = reg_idx_e'(addr);
    assign locked = win_m.hi[LOCK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            dom_en  <= 1'b0;
            win_m   <= '0;
            win_s   <= '0;
            sw_word <= '0;
            sw_req  <= 1'b0;
        end else begin
            if (we) begin
                case (sel)
                    RI_CTRL:   dom_en <= wdata[0];
                    RI_MLO:    if (!locked) win_m.lo <= wdata;
                    RI_MHI:    if (!locked) win_m.hi <= wdata & HI_KEEP;
                    RI_SLO:    if (!locked) win_s.lo <= wdata;
                    RI_SHI:    if (!locked) win_s.hi <= wdata & HI_KEEP;
                    RI_SWSEND: sw_word <= wdata & SW_KEEP;
                    default:   ;
                endcase
            end
            if (we && sel == RI_SWSEND) begin
                sw_req <= 1'b1;
            end else if (sw_take) begin
                sw_req <= 1'b0;
            end
        end
    end

    always_comb begin
        case (sel)
            RI_CTRL:   rdata = {{(WORD_W-1){1'b0}}, dom_en};
            RI_MLO:    rdata = win_m.lo;
            RI_MHI:    rdata = win_m.hi;
            RI_SLO:    rdata = win_s.lo;
            RI_SHI:    rdata = win_s.hi;
            RI_SWSEND: rdata = sw_word;
            default:   rdata = '0;
        endcase
    end

    // R3: a set lock freezes both windows
    assert_lock_hold_R3: assert property (@(posedge clk) disable iff (rst)
        locked |=> (locked && $stable(win_m) && $stable(win_s)));

    // R2: an unlocked high write keeps only the masked bits
    assert_hi_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (we && sel == RI_SHI && !locked) |=> (win_s.hi == ($past(wdata) & HI_KEEP)));

    // R10: a stored send word never carries a guest field
    assert_sw_guest_R10: assert property (@(posedge clk) disable iff (rst)
        sw_req |-> (sw_word[17:12] == 6'd0));

endmodule

// File: rtl/msi_src_pick.sv
module msi_src_pick #(
    parameter int NSRC = 8,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  rdy,
    output logic [NSRC-1:0]  grant,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [NSRC:0] seen;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NSRC; g++) begin : g_chain
        assign seen[g+1] = seen[g] | rdy[g];
        assign grant[g]  = rdy[g] & ~seen[g];
    end

    assign found = seen[NSRC];

    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/msi_launch.sv
module msi_launch
    import msi_pkg::*;
#(
    parameter int NSRC = 8,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        dom_is_mach,
    input  win_t                        win_m,
    input  win_t                        win_s,
    input  logic [WORD_W-1:0]           sw_word,
    input  logic                        sw_req,
    input  logic                        found,
    input  logic [NSRC-1:0]             grant,
    input  logic [IDX_W-1:0]            idx,
    input  logic [NSRC-1:0][WORD_W-1:0] tgt_words,
    input  logic                        ready,
    output logic                        sw_take,
    output logic [NSRC-1:0]             pend_clr,
    output logic                        valid,
    output logic [MADDR_W-1:0]          addr,
    output logic [WORD_W-1:0]           data
);

    win_t  win_sel;
    dest_t src_d, sw_d, pick_d;
    msg_t  nxt;
    logic  idle, take_src;

    assign win_sel = dom_is_mach ? win_m : win_s;

    always_comb begin
        src_d = unpack_target(tgt_words[idx]);
        if (dom_is_mach) src_d.guest = '0;
        sw_d       = unpack_target(sw_word);
        sw_d.guest = '0;
    end

    assign idle     = !valid;
    assign sw_take  = idle && sw_req;
    assign take_src = idle && !sw_req && found;
    assign pend_clr = take_src ? grant : '0;
    assign pick_d   = sw_take ? sw_d : src_d;
    assign nxt      = build_msg(win_sel, pick_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            addr  <= '0;
            data  <= '0;
        end else if (sw_take || take_src) begin
            valid <= 1'b1;
            addr  <= nxt.addr;
            data  <= nxt.data;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    // R9: an unaccepted request holds its address and data
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(addr) && $stable(data)));

    // R9: after a handshake the request line drops
    assert_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && ready) |=> !valid);

    // R7: a pending clear is followed by a launched request
    assert_clr_launch_R7: assert property (@(posedge clk) disable iff (rst)
        (|pend_clr) |=> valid);

endmodule

// File: rtl/msi_composer.sv
module msi_composer
    import msi_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dom_is_mach,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NSRC*32-1:0]   src_target,
    input  logic [NSRC-1:0]      src_pend,
    input  logic [NSRC-1:0]      src_en,
    output logic [NSRC-1:0]      pend_clr,
    output logic                 msi_valid,
    input  logic                 msi_ready,
    output logic [63:0]          msi_addr,
    output logic [31:0]          msi_data
);

    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic                        dom_en, sw_req, sw_take, found;
    win_t                        win_m, win_s;
    logic [WORD_W-1:0]           sw_word;
    logic [NSRC-1:0]             rdy, grant;
    logic [IDX_W-1:0]            idx;
    logic [NSRC-1:0][WORD_W-1:0] tgt_words;

    assign tgt_words = src_target;
    assign rdy       = {NSRC{dom_en}} & src_en & src_pend;

    msi_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .sw_take (sw_take),
        .rdata   (reg_rdata),
        .dom_en  (dom_en),
        .win_m   (win_m),
        .win_s   (win_s),
        .sw_word (sw_word),
        .sw_req  (sw_req)
    );

    msi_src_pick #(.NSRC(NSRC)) u_pick (
        .rdy   (rdy),
        .grant (grant),
        .found (found),
        .idx   (idx)
    );

    msi_launch #(.NSRC(NSRC)) u_launch (
        .clk         (clk),
        .rst         (rst),
        .dom_is_mach (dom_is_mach),
        .win_m       (win_m),
        .win_s       (win_s),
        .sw_word     (sw_word),
        .sw_req      (sw_req),
        .found       (found),
        .grant       (grant),
        .idx         (idx),
        .tgt_words   (tgt_words),
        .ready       (msi_ready),
        .sw_take     (sw_take),
        .pend_clr    (pend_clr),
        .valid       (msi_valid),
        .addr        (msi_addr),
        .data        (msi_data)
    );

    // R7: at most one source cleared per cycle
    assert_clr_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pend_clr));

    // R4: a cleared source was enabled, pending and in an enabled domain
    assert_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (|pend_clr) |-> (dom_en && ((pend_clr & src_en & src_pend) != '0)));

    // R8: no lower-numbered ready source is passed over
    assert_lowest_R8: assert property (@(posedge clk) disable iff (rst)
        (|pend_clr) |-> (((pend_clr - 1'b1) & src_en & src_pend) == '0));

    // R8: software send wins over sources
    assert_sw_first_R8: assert property (@(posedge clk) disable iff (rst)
        (sw_req && !msi_valid) |-> (pend_clr == '0));

endmodule

// File: tb/sim_msi_composer.sv
`timescale 1ns/1ps
module sim_msi_composer;

    localparam int NSRC = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tb_mach = 1'b1;
    logic              tb_we = 1'b0;
    logic [2:0]        tb_addr = '0;
    logic [31:0]       tb_wd = '0;
    logic [NSRC-1:0]   tb_pend = '0;
    logic [NSRC-1:0]   tb_en = '0;
    logic              tb_rdy = 1'b0;
    logic [31:0]       tb_tgt [NSRC];
    logic [NSRC*32-1:0] tgt_flat;

    logic [31:0]       reg_rdata;
    logic [NSRC-1:0]   pend_clr;
    logic              msi_valid;
    logic [63:0]       msi_addr;
    logic [31:0]       msi_data;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    bit          m_dom, m_swreq, m_vld;
    bit [31:0]   m_mlo, m_mhi, m_slo, m_shi, m_sw;
    bit [63:0]   m_addr;
    bit [31:0]   m_data;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NSRC; i++) tgt_flat[i*32 +: 32] = tb_tgt[i];
    end

    msi_composer #(.NSRC(NSRC)) u0 (
        .clk(clk), .rst(rst), .dom_is_mach(tb_mach),
        .reg_we(tb_we), .reg_addr(tb_addr), .reg_wdata(tb_wd), .reg_rdata(reg_rdata),
        .src_target(tgt_flat), .src_pend(tb_pend), .src_en(tb_en),
        .pend_clr(pend_clr), .msi_valid(msi_valid), .msi_ready(tb_rdy),
        .msi_addr(msi_addr), .msi_data(msi_data)
    );

    task automatic chk(string tag, longint unsigned got, longint unsigned exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit [63:0] ref_addr(bit [31:0] lo, bit [31:0] hi, int hart, int guest);
        int lw = (hi >> 12) & 15;
        int hw = (hi >> 16) & 7;
        int ls = (hi >> 20) & 7;
        int hs = (hi >> 24) & 31;
        bit [63:0] g, p;
        g = 64'(hart) >> lw;
        g = g % (64'd1 << hw);
        p = (64'(hi & 32'hFFF) << 32) | 64'(lo);
        p = p | (g << (hs + 12));
        p = p | ((64'(hart) % (64'd1 << lw)) << ls);
        p = p | (64'(guest) % (64'd1 << ls));
        return p << 12;
    endfunction

    function automatic bit [31:0] ref_read(int a);
        case (a)
            0: return {31'd0, m_dom};
            1: return m_mlo;
            2: return m_mhi;
            3: return m_slo;
            4: return m_shi;
            5: return m_sw;
            default: return 32'd0;
        endcase
    endfunction

    // -2 none, -1 software send, otherwise the source index
    function automatic int ref_grant();
        if (m_vld) return -2;
        if (m_swreq) return -1;
        if (m_dom) begin
            for (int i = 0; i < NSRC; i++)
                if (tb_en[i] && tb_pend[i]) return i;
        end
        return -2;
    endfunction

    task automatic ref_launch(bit [31:0] w, bit use_guest);
        bit [31:0] lo = tb_mach ? m_mlo : m_slo;
        bit [31:0] hi = tb_mach ? m_mhi : m_shi;
        int guest = use_guest ? int'((w >> 12) & 63) : 0;
        m_vld  = 1;
        m_addr = ref_addr(lo, hi, int'((w >> 18) & 14'h3FFF), guest);
        m_data = w & 32'h7FF;
    endtask

    task automatic tick();
        int g;
        bit lock;
        #1;
        g = ref_grant();
        chk("R7 pend_clr", 64'(pend_clr), (g >= 0) ? (64'd1 << g) : 64'd0);
        chk("R2 reg_rdata", 64'(reg_rdata), 64'(ref_read(int'(tb_addr))));
        lock = m_mhi[31];
        if (m_vld && tb_rdy) m_vld = 0;
        if (g == -1) begin
            ref_launch(m_sw, 0);
            m_swreq = 0;
        end else if (g >= 0) begin
            ref_launch(tb_tgt[g], !tb_mach);
        end
        if (tb_we) begin
            case (int'(tb_addr))
                0: m_dom = tb_wd[0];
                1: if (!lock) m_mlo = tb_wd;
                2: if (!lock) m_mhi = tb_wd & 32'h9F77FFFF;
                3: if (!lock) m_slo = tb_wd;
                4: if (!lock) m_shi = tb_wd & 32'h9F77FFFF;
                5: begin m_sw = tb_wd & 32'hFFFC0FFF; m_swreq = 1; end
                default: ;
            endcase
        end
        @(negedge clk);
        if (g >= 0) tb_pend[g] = 1'b0;
        chk("R9 msi_valid", 64'(msi_valid), 64'(m_vld));
        if (m_vld) begin
            chk("R5 msi_addr", msi_addr, m_addr);
            chk("R11 msi_data", 64'(msi_data), 64'(m_data));
        end
        tb_we = 1'b0;
    endtask

    task automatic wr(int a, bit [31:0] d);
        tb_we = 1'b1; tb_addr = 3'(a); tb_wd = d;
        tick();
    endtask

    task automatic rd_chk(int a, bit [31:0] exp, string tag);
        tb_addr = 3'(a);
        #1;
        chk(tag, 64'(reg_rdata), 64'(exp));
        tick();
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog R9 got=hung exp=finished");
        if (!done) begin
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSRC; i++) tb_tgt[i] = (i << 18) | (32'h40 + i);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1 msi_valid", 64'(msi_valid), 0);
        chk("R1 pend_clr", 64'(pend_clr), 0);
        for (int a = 0; a < 8; a++) rd_chk(a, 32'd0, "R1 reg after reset");

        // R2 masking of the high registers
        wr(4, 32'hFFFF_FFFF);
        rd_chk(4, 32'h9F77_FFFF, "R2 shi mask");
        wr(2, 32'h7FFF_FFFF);
        rd_chk(2, 32'h1F77_FFFF, "R2 mhi mask");

        // R5 directed machine address
        tb_mach = 1'b1;
        wr(1, 32'h0001_2340);
        wr(2, 32'h0413_2005);
        wr(3, 32'h0001_2340);
        wr(4, 32'h0413_2005);
        wr(0, 32'd1);
        tb_tgt[3] = 32'h002C_5123;
        tb_en = 8'h08; tb_pend = 8'h08; tb_rdy = 1'b0;
        tick();
        chk("R5 machine addr", msi_addr, 64'h0000_5000_3234_6000);
        chk("R6 machine guest zero", msi_addr, 64'h0000_5000_3234_6000);
        chk("R11 data zero-extended", 64'(msi_data), 64'h123);
        tick(); tick();
        chk("R9 held while not ready", 64'(msi_valid), 1);
        tb_rdy = 1'b1;
        tick();
        chk("R9 drop after handshake", 64'(msi_valid), 0);

        // R6 supervisor window with guest
        tb_mach = 1'b0;
        tb_pend = 8'h08;
        tick();
        chk("R6 supervisor addr", msi_addr, 64'h0000_5000_3234_7000);
        tick();

        // R8 lowest first
        tb_tgt[3] = (3 << 18) | 32'h43;
        tb_en = 8'hFF; tb_pend = 8'h64;
        tick();
        chk("R8 first served src2", 64'(msi_data), 64'h42);
        tick(); tick();
        chk("R8 second served src5", 64'(msi_data), 64'h45);
        tick(); tick(); tick(); tick();

        // R4 disabled domain blocks sources
        wr(0, 32'd0);
        tb_pend = 8'h11;
        repeat (4) tick();
        chk("R4 no send when domain off", 64'(msi_valid), 0);
        tb_en = 8'h00;
        wr(0, 32'd1);
        repeat (3) tick();
        chk("R4 no send when source off", 64'(msi_valid), 0);

        // R10 software send before sources
        tb_en = 8'h10; tb_rdy = 1'b0;
        tick();
        tb_pend[1] = 1'b1; tb_en = 8'h12;
        wr(5, 32'hFFFF_FFFF);
        rd_chk(5, 32'hFFFC_0FFF, "R10 stored guest cleared");
        tb_rdy = 1'b1;
        tick(); tick();
        chk("R10 software message data", 64'(msi_data), 64'h7FF);
        chk("R8 software before source", 64'(tb_pend[1]), 1);
        tick(); tick();
        chk("R8 source after software", 64'(msi_data), 64'h41);
        tick();

        // random traffic
        for (int c = 0; c < 3000; c++) begin
            tb_rdy = ($urandom % 4) != 0;
            if ($urandom % 5 == 0) tb_pend[$urandom % NSRC] = 1'b1;
            if (c % 50 == 0) tb_en = 8'($urandom);
            if (c % 500 == 250) tb_mach = ~tb_mach;
            if ($urandom % 40 == 0) tb_tgt[$urandom % NSRC] = $urandom;
            tb_addr = 3'($urandom % 8);
            if ($urandom % 16 == 0) begin
                tb_we = 1'b1;
                tb_wd = $urandom;
                if (tb_addr == 3'd2) tb_wd[31] = 1'b0;
                if (tb_addr == 3'd0) tb_wd[0] = ($urandom % 4) != 0;
            end
            tick();
        end

        // R3 lock
        wr(2, 32'h8000_0ABC);
        wr(1, 32'h1111_1111);
        wr(2, 32'h0000_0000);
        wr(3, 32'h3333_3333);
        wr(4, 32'h0000_0001);
        rd_chk(2, 32'h8000_0ABC, "R3 mhi locked");
        rd_chk(1, m_mlo, "R3 mlo locked");
        chk("R3 mlo unchanged", 64'(m_mlo == 32'h1111_1111), 0);
        chk("R3 slo unchanged", 64'(m_slo == 32'h3333_3333), 0);
        repeat (4) tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule